// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block takes eight level-sensitive PCI interrupt lines, named A through H, and presents them to two interrupt controllers at once. For the 16-input legacy controller, each line has a route byte that names a legacy input and can switch the line off. Any number of lines may name the same input, and their levels are ORed together there. For the 24-input APIC, the mapping is fixed: line n always drives APIC input 16+n, so no two lines share an APIC pin. A control byte selects which input, on either controller, also carries the stored power-management SCI level.

Software writes the eight route bytes and the control byte through a single-cycle write port. Addresses 0 to 3 hold the bytes for lines A–D and addresses 4 to 7 hold the bytes for lines E–H. A write takes effect at the next rising clock edge. All interrupt outputs and the per-line mode report are combinational functions of the stored bytes, the stored SCI level and the live line inputs. The controllers themselves and the bus protocol in front of the write port lie outside the block.

Top module: `pirq_router`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first write, every route byte reads as 0x80 (disabled), the control byte as 0x00 and the stored SCI level as 0. With all lines low, every legacy and APIC output is 0 and every line reports APIC mode (2'b10).
- R2: When `cfg_we` is high at a rising edge, `cfg_addr` 0–7 writes `cfg_wdata` to the route byte of line A–H in that order, and address 8 writes the control byte. Addresses 9–15 change nothing. Without `cfg_we`, no stored byte changes.
- R3: Route byte bits 4:0 hold an IRQ number and bit 7 is the disable flag. `legacy_irq[k]` is the OR of the inputs of every line whose disable flag is 0 and whose IRQ number equals k, ORed with the SCI contribution of R7.
- R4: A line whose route byte has bit 7 set adds nothing to any legacy output, whatever its IRQ number.
- R5: `apic_irq[16+n]` follows `pirq_in[n]` for every line n, whatever its route byte holds. APIC inputs 0–15 carry no line.
- R6: Control byte bits 2:0 select the SCI output: 0→9, 1→10, 2→11, 4→20, 5→21. Codes 3, 6 and 7 are reserved, and with a reserved code the SCI drives no output. Control bits 7:3 are ignored.
- R7: `sci_in` is stored at each rising edge. The stored level is ORed into `apic_irq[sel]`, and also into `legacy_irq[sel]` when sel is below 16.
- R8: `line_mode[2n+1:2n]` reports line n as follows: 2'b01 (legacy) when bit 7 is clear and the IRQ number is below 16; 2'b10 (APIC) when bit 7 is set; 2'b00 (off) when bit 7 is clear and the IRQ number is 16 or more. An off line drives no legacy output.
- R9: A change on `pirq_in` appears on the legacy and APIC outputs in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the register port |
| cfg_addr | input | 4 | Write address: 0–7 route bytes for lines A–H, 8 control byte |
| cfg_wdata | input | 8 | Write data |
| pirq_in | input | 8 | Interrupt line levels, bit 0 = line A |
| sci_in | input | 1 | SCI level, stored each clock |
| legacy_irq | output | 16 | Legacy controller input levels |
| apic_irq | output | 24 | APIC input levels |
| line_mode | output | 16 | Two-bit routing mode per line, line A in bits 1:0 |

## Verification
The assertions take for granted that every input is free of X and is stable around each rising edge. They also assume that `cfg_addr` and `cfg_wdata` carry meaning only in a cycle where `cfg_we` is high. The stored-byte and SCI checks depend on an internal flag that only becomes valid on the first edge after reset. The bench therefore drives every input on the falling edge, so each input has been stable for half a period before the edge that samples it. It holds `cfg_we` for exactly one cycle per write and keeps all inputs at known values from time zero, including while reset is held.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    // Per-line routing mode reported on line_mode.
    typedef enum logic [1:0] {
        LM_OFF    = 2'b00,
        LM_LEGACY = 2'b01,
        LM_APIC   = 2'b10
    } line_mode_e;

    // Decoded SCI destination.
    typedef struct packed {
        logic       valid;
        logic [4:0] idx;
    } sci_route_t;

    // Control byte bits 2:0 select the SCI output number.
    function automatic sci_route_t sci_decode(input logic [2:0] code);
        sci_route_t r;
        r.valid = 1'b1;
        r.idx   = 5'd0;
        unique case (code)
            3'd0: r.idx = 5'd9;
            3'd1: r.idx = 5'd10;
            3'd2: r.idx = 5'd11;
            3'd4: r.idx = 5'd20;
            3'd5: r.idx = 5'd21;
            default: r.valid = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs #(
    parameter int          N_LINES    = 8,
    parameter int          ADDR_W     = 4,
    parameter logic [7:0]  ROUTE_DFLT = 8'h80,
    parameter logic [7:0]  CTRL_DFLT  = 8'h00
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [ADDR_W-1:0]        cfg_addr,
    input  logic [7:0]               cfg_wdata,
    input  logic                     sci_in,
    output logic [N_LINES-1:0][7:0]  route_q,
    output logic [7:0]               ctrl_q,
    output logic                     sci_q
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(N_LINES);

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    for (genvar n = 0; n < N_LINES; n++) begin : g_line
        logic [7:0] byte_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                byte_q <= ROUTE_DFLT;
            else if (cfg_we && cfg_addr == ADDR_W'(n))
                byte_q <= cfg_wdata;
        end

        assign route_q[n] = byte_q;

        // Only a write to this line's address may change its byte.
        assert_route_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (past_ok && !($past(cfg_we) && $past(cfg_addr) == ADDR_W'(n)))
            |-> route_q[n] == $past(route_q[n]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= CTRL_DFLT;
        else if (cfg_we && cfg_addr == CTRL_ADDR)
            ctrl_q <= cfg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sci_q <= 1'b0;
        else        sci_q <= sci_in;
    end

    assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !($past(cfg_we) && $past(cfg_addr) == CTRL_ADDR))
        |-> ctrl_q == $past(ctrl_q));

    assert_sci_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> sci_q == $past(sci_in));

endmodule

// File: rtl/pirq_legacy_merge.sv
module pirq_legacy_merge
    import pirq_pkg::*;
#(
    parameter int N_LINES  = 8,
    parameter int N_LEGACY = 16,
    parameter int IRQ_W    = 5,
    parameter int DIS_BIT  = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_LINES-1:0]       pirq_in,
    input  logic [N_LINES-1:0][7:0]  route_q,
    input  logic                     sci_q,
    input  sci_route_t               sci_sel,
    output logic [N_LEGACY-1:0]      legacy_irq,
    output logic [N_LINES-1:0][1:0]  line_mode
);
    localparam int LIDX_W = $clog2(N_LEGACY);

    logic [N_LINES-1:0]             route_on;
    logic [N_LINES-1:0][IRQ_W-1:0]  irq_num;
    logic [N_LINES-1:0]             unused_route;
    logic [N_LEGACY-1:0][N_LINES-1:0] hit;

    for (genvar n = 0; n < N_LINES; n++) begin : g_line
        assign route_on[n]     = ~route_q[n][DIS_BIT];
        assign irq_num[n]      = route_q[n][IRQ_W-1:0];
        assign unused_route[n] = ^route_q[n][DIS_BIT-1:IRQ_W];

        always_comb begin
            line_mode_e m;
            if (!route_on[n])
                m = LM_APIC;
            else if (int'(irq_num[n]) < N_LEGACY)
                m = LM_LEGACY;
            else
                m = LM_OFF;
            line_mode[n] = m;
        end

        assert_legacy_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (line_mode[n] == LM_LEGACY && pirq_in[n])
            |-> legacy_irq[irq_num[n][LIDX_W-1:0]]);
    end

    for (genvar k = 0; k < N_LEGACY; k++) begin : g_out
        for (genvar n = 0; n < N_LINES; n++) begin : g_hit
            assign hit[k][n] = route_on[n] && pirq_in[n] && (irq_num[n] == IRQ_W'(k));
        end
        assign legacy_irq[k] = (|hit[k])
                             | (sci_q && sci_sel.valid && sci_sel.idx == 5'(k));
    end

endmodule

// File: rtl/pirq_apic_map.sv
module pirq_apic_map
    import pirq_pkg::*;
#(
    parameter int N_LINES   = 8,
    parameter int N_APIC    = 24,
    parameter int APIC_BASE = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_LINES-1:0]   pirq_in,
    input  logic                 sci_q,
    input  sci_route_t           sci_sel,
    output logic [N_APIC-1:0]    apic_irq
);
    logic [N_APIC-1:0] sci_hit;
    logic [N_APIC-1:0] line_lvl;

    for (genvar g = 0; g < N_APIC; g++) begin : g_pin
        if (g >= APIC_BASE && g < APIC_BASE + N_LINES) begin : g_line
            assign line_lvl[g] = pirq_in[g-APIC_BASE];
        end else begin : g_none
            assign line_lvl[g] = 1'b0;
        end
        assign sci_hit[g]  = sci_q && sci_sel.valid && sci_sel.idx == 5'(g);
        assign apic_irq[g] = line_lvl[g] | sci_hit[g];
    end

    for (genvar n = 0; n < N_LINES; n++) begin : g_chk
        assert_apic_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
            pirq_in[n] |-> apic_irq[APIC_BASE+n]);
    end

    // A reserved SCI code leaves the pins below the line block quiet.
    assert_sci_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sci_sel.valid |-> apic_irq[APIC_BASE-1:0] == '0);

endmodule

// File: rtl/pirq_router.sv
module pirq_router
    import pirq_pkg::*;
#(
    parameter int N_LINES   = 8,
    parameter int N_LEGACY  = 16,
    parameter int N_APIC    = 24,
    parameter int ADDR_W    = 4,
    parameter int IRQ_W     = 5,
    parameter int DIS_BIT   = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [ADDR_W-1:0]      cfg_addr,
    input  logic [7:0]             cfg_wdata,
    input  logic [N_LINES-1:0]     pirq_in,
    input  logic                   sci_in,
    output logic [N_LEGACY-1:0]    legacy_irq,
    output logic [N_APIC-1:0]      apic_irq,
    output logic [2*N_LINES-1:0]   line_mode
);
    localparam int APIC_BASE = N_LEGACY;

    logic [N_LINES-1:0][7:0] route_q;
    logic [7:0]              ctrl_q;
    logic                    sci_q;
    sci_route_t              sci_sel;
    logic [N_LINES-1:0][1:0] mode_w;
    logic                    unused_ctrl;

    pirq_route_regs #(
        .N_LINES (N_LINES),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .sci_in    (sci_in),
        .route_q   (route_q),
        .ctrl_q    (ctrl_q),
        .sci_q     (sci_q)
    );

    assign sci_sel     = sci_decode(ctrl_q[2:0]);
    assign unused_ctrl = ^ctrl_q[7:3];

    pirq_legacy_merge #(
        .N_LINES  (N_LINES),
        .N_LEGACY (N_LEGACY),
        .IRQ_W    (IRQ_W),
        .DIS_BIT  (DIS_BIT)
    ) u_legacy (
        .clk        (clk),
        .rst_n      (rst_n),
        .pirq_in    (pirq_in),
        .route_q    (route_q),
        .sci_q      (sci_q),
        .sci_sel    (sci_sel),
        .legacy_irq (legacy_irq),
        .line_mode  (mode_w)
    );

    assign line_mode = mode_w;

    pirq_apic_map #(
        .N_LINES   (N_LINES),
        .N_APIC    (N_APIC),
        .APIC_BASE (APIC_BASE)
    ) u_apic (
        .clk      (clk),
        .rst_n    (rst_n),
        .pirq_in  (pirq_in),
        .sci_q    (sci_q),
        .sci_sel  (sci_sel),
        .apic_irq (apic_irq)
    );

    // No line level and no stored SCI: every legacy input must be low.
    assert_legacy_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pirq_in == '0 && !sci_q) |-> legacy_irq == '0);

endmodule

// File: tb/sim_pirq_router.sv
module sim_pirq_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = 4'd0;
    logic [7:0]  cfg_wdata = 8'd0;
    logic [7:0]  pirq_in = 8'd0;
    logic        sci_in = 1'b0;
    logic [15:0] legacy_irq;
    logic [23:0] apic_irq;
    logic [15:0] line_mode;

    always #10 clk = ~clk;   // 50 MHz

    pirq_router u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .pirq_in    (pirq_in),
        .sci_in     (sci_in),
        .legacy_irq (legacy_irq),
        .apic_irq   (apic_irq),
        .line_mode  (line_mode)
    );

    // Reference state, updated from the requirements.
    int    m_route [8];
    int    m_ctrl;
    int    m_sci;
    int    checks = 0;
    int    fails  = 0;
    string tag    = "R1";

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) m_route[i] = 'h80;
            m_ctrl = 0;
            m_sci  = 0;
        end else begin
            if (cfg_we) begin
                if (cfg_addr < 8)       m_route[cfg_addr] = cfg_wdata;
                else if (cfg_addr == 8) m_ctrl = cfg_wdata;
            end
            m_sci = sci_in;
        end
    end

    function automatic int sci_target(int ctrl);
        case (ctrl & 7)
            0: return 9;
            1: return 10;
            2: return 11;
            4: return 20;
            5: return 21;
            default: return -1;
        endcase
    endfunction

    task automatic compare();
        logic [15:0] e_leg;
        logic [23:0] e_apic;
        logic [15:0] e_mode;
        int sel;
        e_leg = '0; e_apic = '0; e_mode = '0;
        sel = sci_target(m_ctrl);
        for (int n = 0; n < 8; n++) begin
            int irq;
            bit off;
            irq = m_route[n] % 32;
            off = (m_route[n] / 128) % 2 == 1;
            if (pirq_in[n]) e_apic[16+n] = 1'b1;
            if (off) begin
                e_mode[2*n +: 2] = 2'b10;
            end else if (irq < 16) begin
                e_mode[2*n +: 2] = 2'b01;
                if (pirq_in[n]) e_leg[irq] = 1'b1;
            end else begin
                e_mode[2*n +: 2] = 2'b00;
            end
        end
        if (m_sci != 0 && sel >= 0) begin
            e_apic[sel] = 1'b1;
            if (sel < 16) e_leg[sel] = 1'b1;
        end
        checks += 3;
        if (legacy_irq !== e_leg) begin
            fails++;
            $display("FAIL %s legacy_irq actual=%h expected=%h", tag, legacy_irq, e_leg);
        end
        if (apic_irq !== e_apic) begin
            fails++;
            $display("FAIL %s apic_irq actual=%h expected=%h", tag, apic_irq, e_apic);
        end
        if (line_mode !== e_mode) begin
            fails++;
            $display("FAIL %s line_mode actual=%h expected=%h", tag, line_mode, e_mode);
        end
    endtask

    task automatic cyc(input bit we, input logic [3:0] a, input logic [7:0] d,
                       input logic [7:0] p, input bit s);
        @(negedge clk);
        cfg_we = we; cfg_addr = a; cfg_wdata = d; pirq_in = p; sci_in = s;
        #2;
        compare();
    endtask

    logic [7:0] pat = 8'h5A;
    task automatic next_pat();
        pat = {pat[6:0], pat[7] ^ pat[5] ^ pat[4] ^ pat[3]};
    endtask

    task automatic run_pats(input int cnt, input bit s);
        for (int i = 0; i < cnt; i++) begin
            next_pat();
            cyc(1'b0, 4'd0, 8'd0, pat, s);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        tag = "R1";
        repeat (3) cyc(1'b0, 4'd0, 8'd0, 8'h00, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        cyc(1'b0, 4'd0, 8'd0, 8'h00, 1'b0);
        cyc(1'b0, 4'd0, 8'd0, 8'h00, 1'b0);

        // R5: all routes disabled, lines reach only APIC pins
        tag = "R5";
        cyc(1'b0, 4'd0, 8'd0, 8'hFF, 1'b0);
        run_pats(6, 1'b0);

        // R2: load route bytes
        tag = "R2";
        cyc(1'b1, 4'd0, 8'h05, 8'h00, 1'b0);
        cyc(1'b1, 4'd1, 8'h05, 8'h00, 1'b0);
        cyc(1'b1, 4'd2, 8'h03, 8'h00, 1'b0);
        cyc(1'b1, 4'd3, 8'h0E, 8'h00, 1'b0);
        cyc(1'b1, 4'd4, 8'h0C, 8'h00, 1'b0);
        cyc(1'b1, 4'd5, 8'h8C, 8'h00, 1'b0);
        cyc(1'b1, 4'd6, 8'h0F, 8'h00, 1'b0);
        cyc(1'b1, 4'd7, 8'h00, 8'h00, 1'b0);

        // R3: shared legacy inputs, several patterns
        tag = "R3";
        cyc(1'b0, 4'd0, 8'd0, 8'h01, 1'b0);
        cyc(1'b0, 4'd0, 8'd0, 8'h02, 1'b0);
        cyc(1'b0, 4'd0, 8'd0, 8'h03, 1'b0);
        run_pats(16, 1'b0);

        // R9: line changes between edges show up at once
        tag = "R9";
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            pirq_in = 8'h10; #2; compare();
            pirq_in = 8'h81; #2; compare();
            pirq_in = 8'h00; #2; compare();
        end

        // R4: disable flag with a valid IRQ number
        tag = "R4";
        cyc(1'b1, 4'd1, 8'h85, 8'h02, 1'b0);
        cyc(1'b0, 4'd0, 8'd0, 8'h02, 1'b0);
        cyc(1'b1, 4'd0, 8'hE5, 8'h03, 1'b0);
        run_pats(10, 1'b0);

        // R8: enabled but out-of-range IRQ numbers
        tag = "R8";
        cyc(1'b1, 4'd3, 8'h14, 8'h08, 1'b0);
        cyc(1'b1, 4'd6, 8'h10, 8'h48, 1'b0);
        cyc(1'b1, 4'd2, 8'h1F, 8'h4C, 1'b0);
        cyc(1'b1, 4'd0, 8'h07, 8'hFF, 1'b0);
        run_pats(10, 1'b0);

        // R6 and R7: every SCI selection code, including reserved ones
        for (int c = 0; c < 8; c++) begin
            tag = "R6";
            cyc(1'b1, 4'd8, 8'(c) | 8'hF8 & 8'(c * 8), 8'h00, 1'b0);
            cyc(1'b0, 4'd0, 8'd0, 8'h00, 1'b1);
            tag = "R7";
            cyc(1'b0, 4'd0, 8'd0, 8'h00, 1'b1);
            cyc(1'b0, 4'd0, 8'd0, 8'h00, 1'b0);
            cyc(1'b0, 4'd0, 8'd0, 8'h00, 1'b0);
            run_pats(3, 1'b1);
        end

        // R2: addresses 9-15 and idle strobes leave state alone
        tag = "R2";
        cyc(1'b1, 4'd0, 8'h09, 8'h00, 1'b0);
        for (int a = 9; a < 16; a++) cyc(1'b1, 4'(a), 8'h01, 8'hFF, 1'b1);
        cyc(1'b0, 4'd8, 8'h05, 8'hFF, 1'b1);
        cyc(1'b0, 4'd1, 8'h00, 8'hFF, 1'b1);
        run_pats(6, 1'b1);

        // R1: reset in the middle of operation
        tag = "R1";
        @(negedge clk); rst_n = 1'b0;
        #2; compare();
        cyc(1'b0, 4'd0, 8'd0, 8'h00, 1'b1);
        @(negedge clk); rst_n = 1'b1;
        cyc(1'b0, 4'd0, 8'd0, 8'h00, 1'b0);
        cyc(1'b0, 4'd0, 8'd0, 8'hA5, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule